// File: doc/BRIEF.md
# USB Frame Number Tracker

This block holds the 11-bit USB frame number for a device-side controller. Each time the token decoder reports a valid start-of-frame, the number carried in that token is copied into the block. While the local frame timer has lost lock to the host, the timer issues its own pseudo start-of-frame pulses instead, and each one advances the held number by one. Downstream logic uses the number as a timestamp.

The number can be read as two byte registers on a plain memory-mapped read port. The low byte sits at address FFFBh and the upper three bits at FFFAh. Neither register can be written: there is no write path into the block. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `sof_frame_counter`

## Requirements
- R1: A synchronous active-high reset clears the frame number to 0, so both byte registers then read 0.
- R2: When `sof_valid_i` is high at a clock edge, the frame number becomes `sof_frame_i`, whatever the lock flag is.
- R3: When `pseudo_sof_i` is high, `timer_locked_i` is low and `sof_valid_i` is low at an edge, the frame number becomes the previous value plus one.
- R4: A pseudo start-of-frame increment from 2047 gives 0.
- R5: If `sof_valid_i` and an accepted pseudo start-of-frame come in the same cycle, the token value is taken and no increment happens.
- R6: A `pseudo_sof_i` pulse has no effect on the frame number while `timer_locked_i` is high.
- R7: A read (`bus_rd_i` high) at address 16'hFFFB returns frame number bits 7:0 on `bus_rdata_o`.
- R8: A read at address 16'hFFFA returns frame number bits 10:8 on bits 2:0 of `bus_rdata_o`, and bits 7:3 read as 0.
- R9: `bus_rdata_o` is 0 for a read at any other address and whenever `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_valid_i | input | 1 | One-cycle strobe: a valid start-of-frame token was decoded |
| sof_frame_i | input | 11 | Frame-number field of that token |
| pseudo_sof_i | input | 1 | One-cycle strobe from the local frame timer |
| timer_locked_i | input | 1 | High while the local frame timer tracks the host |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 16 | Read address |
| bus_rdata_o | output | 8 | Read data, combinational |
| frame_num_o | output | 11 | Current frame number |

## Verification
The assertions assume that `sof_valid_i` and `pseudo_sof_i` are held low while reset is asserted. They also assume that every input is settled before each rising edge, so that the value captured from `sof_frame_i` is the value sampled at that edge. The bench drives all inputs at the falling edge and drops both strobes during reset, so it stays inside these assumptions. Reads are issued only between update edges, while the stored number is stable.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Default geometry of the tracker
    localparam int unsigned FRAME_W_DEF  = 11;
    localparam int unsigned BUS_AW_DEF   = 16;
    localparam int unsigned BUS_DW_DEF   = 8;
    localparam logic [15:0] TOP_ADDR_DEF = 16'hFFFB;  // low byte; higher bytes descend

    // What the frame register does at the next edge
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } upd_kind_e;

    // Priority: a decoded token beats a local pseudo strobe
    function automatic upd_kind_e pick_update(input logic sof_seen,
                                              input logic pseudo_seen,
                                              input logic locked);
        if (sof_seen)
            return UPD_LOAD;
        else if (pseudo_seen && !locked)
            return UPD_STEP;
        else
            return UPD_HOLD;
    endfunction

    // Number of bus bytes needed to show a field of width w
    function automatic int unsigned bytes_for(input int unsigned w, input int unsigned dw);
        return (w + dw - 1) / dw;
    endfunction

endpackage

// File: rtl/sfc_update_sel.sv
module sfc_update_sel
    import sfc_pkg::*;
(
    input  logic      sof_valid_i,
    input  logic      pseudo_sof_i,
    input  logic      timer_locked_i,
    output upd_kind_e kind_o
);

    always_comb begin
        kind_o = pick_update(sof_valid_i, pseudo_sof_i, timer_locked_i);
    end

endmodule

// File: rtl/sfc_frame_reg.sv
module sfc_frame_reg
    import sfc_pkg::*;
#(
    parameter int unsigned FRAME_W = FRAME_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  upd_kind_e          kind_i,
    input  logic [FRAME_W-1:0] load_val_i,
    output logic [FRAME_W-1:0] frame_o
);

    localparam logic [FRAME_W-1:0] ONE = FRAME_W'(1);

    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] frame_d;

    // The sum is truncated to the field width, so 2047 + 1 gives 0
    always_comb begin
        unique case (kind_i)
            UPD_LOAD: frame_d = load_val_i;
            UPD_STEP: frame_d = frame_q + ONE;
            default:  frame_d = frame_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= '0;
        else
            frame_q <= frame_d;
    end

    assign frame_o = frame_q;

endmodule

// File: rtl/sfc_read_port.sv
module sfc_read_port
    import sfc_pkg::*;
#(
    parameter int unsigned      FRAME_W  = FRAME_W_DEF,
    parameter int unsigned      BUS_AW   = BUS_AW_DEF,
    parameter int unsigned      BUS_DW   = BUS_DW_DEF,
    parameter logic [BUS_AW-1:0] TOP_ADDR = BUS_AW'(TOP_ADDR_DEF)
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               rd_i,
    input  logic [BUS_AW-1:0]  addr_i,
    output logic [BUS_DW-1:0]  rdata_o
);

    localparam int unsigned NBYTES = bytes_for(FRAME_W, BUS_DW);
    localparam int unsigned PAD_W  = NBYTES * BUS_DW;

    // Zero-extended so the top byte carries 0 in its unused bits
    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(frame_i);

    logic [BUS_DW-1:0] lane [NBYTES];

    // Byte k sits at TOP_ADDR - k and is forced to 0 unless selected
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        localparam logic [BUS_AW-1:0] LANE_ADDR = BUS_AW'(TOP_ADDR - BUS_AW'(k));
        logic hit;
        assign hit     = rd_i && (addr_i == LANE_ADDR);
        assign lane[k] = hit ? padded[k*BUS_DW +: BUS_DW] : '0;
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NBYTES; k++)
            rdata_o = rdata_o | lane[k];
    end

endmodule

// File: rtl/sof_frame_counter.sv
module sof_frame_counter
    import sfc_pkg::*;
#(
    parameter int unsigned       FRAME_W  = FRAME_W_DEF,
    parameter int unsigned       BUS_AW   = BUS_AW_DEF,
    parameter int unsigned       BUS_DW   = BUS_DW_DEF,
    parameter logic [BUS_AW-1:0] TOP_ADDR = BUS_AW'(TOP_ADDR_DEF)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sof_valid_i,
    input  logic [FRAME_W-1:0] sof_frame_i,
    input  logic               pseudo_sof_i,
    input  logic               timer_locked_i,
    input  logic               bus_rd_i,
    input  logic [BUS_AW-1:0]  bus_addr_i,
    output logic [BUS_DW-1:0]  bus_rdata_o,
    output logic [FRAME_W-1:0] frame_num_o
);

    upd_kind_e          kind;
    logic [FRAME_W-1:0] frame;

    sfc_update_sel u_sel (
        .sof_valid_i    (sof_valid_i),
        .pseudo_sof_i   (pseudo_sof_i),
        .timer_locked_i (timer_locked_i),
        .kind_o         (kind)
    );

    sfc_frame_reg #(
        .FRAME_W (FRAME_W)
    ) u_reg (
        .clk        (clk),
        .rst        (rst),
        .kind_i     (kind),
        .load_val_i (sof_frame_i),
        .frame_o    (frame)
    );

    sfc_read_port #(
        .FRAME_W  (FRAME_W),
        .BUS_AW   (BUS_AW),
        .BUS_DW   (BUS_DW),
        .TOP_ADDR (TOP_ADDR)
    ) u_rd (
        .frame_i (frame),
        .rd_i    (bus_rd_i),
        .addr_i  (bus_addr_i),
        .rdata_o (bus_rdata_o)
    );

    assign frame_num_o = frame;

endmodule

// File: rtl/sof_frame_counter_chk.sv
module sof_frame_counter_chk #(
    parameter int unsigned       FRAME_W  = 11,
    parameter int unsigned       BUS_AW   = 16,
    parameter int unsigned       BUS_DW   = 8,
    parameter logic [BUS_AW-1:0] TOP_ADDR = 16'hFFFB
) (
    input logic               clk,
    input logic               rst,
    input logic               sof_valid_i,
    input logic [FRAME_W-1:0] sof_frame_i,
    input logic               pseudo_sof_i,
    input logic               timer_locked_i,
    input logic               bus_rd_i,
    input logic [BUS_AW-1:0]  bus_addr_i,
    input logic [BUS_DW-1:0]  bus_rdata_o,
    input logic [FRAME_W-1:0] frame_num_o
);

    localparam logic [BUS_AW-1:0]  LO_ADDR = TOP_ADDR;
    localparam logic [BUS_AW-1:0]  HI_ADDR = BUS_AW'(TOP_ADDR - BUS_AW'(1));
    localparam int unsigned        HI_BITS = FRAME_W - BUS_DW;
    localparam logic [FRAME_W-1:0] MAXV    = '1;

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> frame_num_o == '0);

    p_sof_load_r2: assert property (@(posedge clk) disable iff (rst)
        sof_valid_i |=> frame_num_o == $past(sof_frame_i));

    p_pseudo_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!sof_valid_i && pseudo_sof_i && !timer_locked_i && frame_num_o != MAXV)
        |=> frame_num_o == $past(frame_num_o) + FRAME_W'(1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!sof_valid_i && pseudo_sof_i && !timer_locked_i && frame_num_o == MAXV)
        |=> frame_num_o == '0);

    p_sof_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (sof_valid_i && pseudo_sof_i && !timer_locked_i)
        |=> frame_num_o == $past(sof_frame_i));

    p_locked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!sof_valid_i && (timer_locked_i || !pseudo_sof_i)) |=> $stable(frame_num_o));

    p_low_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == LO_ADDR) |-> bus_rdata_o == frame_num_o[BUS_DW-1:0]);

    p_high_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == HI_ADDR)
        |-> (bus_rdata_o >> HI_BITS) == '0
            && bus_rdata_o[HI_BITS-1:0] == frame_num_o[FRAME_W-1:BUS_DW]);

    p_other_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_i || (bus_addr_i != LO_ADDR && bus_addr_i != HI_ADDR)) |-> bus_rdata_o == '0);

endmodule

bind sof_frame_counter sof_frame_counter_chk #(
    .FRAME_W  (FRAME_W),
    .BUS_AW   (BUS_AW),
    .BUS_DW   (BUS_DW),
    .TOP_ADDR (TOP_ADDR)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .sof_valid_i    (sof_valid_i),
    .sof_frame_i    (sof_frame_i),
    .pseudo_sof_i   (pseudo_sof_i),
    .timer_locked_i (timer_locked_i),
    .bus_rd_i       (bus_rd_i),
    .bus_addr_i     (bus_addr_i),
    .bus_rdata_o    (bus_rdata_o),
    .frame_num_o    (frame_num_o)
);

// File: tb/sof_frame_counter_tb_top.sv
`timescale 1ns/1ps
module sof_frame_counter_tb_top;

    localparam int          NVEC    = 10;
    localparam logic [15:0] LO_ADDR = 16'hFFFB;
    localparam logic [15:0] HI_ADDR = 16'hFFFA;

    // {sof, sof_value[10:0], pseudo, locked, expected[10:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 11'h123, 1'b0, 1'b0, 11'h123},
        {1'b0, 11'h000, 1'b1, 1'b0, 11'h124},
        {1'b0, 11'h000, 1'b1, 1'b1, 11'h124},
        {1'b0, 11'h555, 1'b0, 1'b0, 11'h124},
        {1'b1, 11'h7FE, 1'b0, 1'b0, 11'h7FE},
        {1'b0, 11'h000, 1'b1, 1'b0, 11'h7FF},
        {1'b0, 11'h000, 1'b1, 1'b0, 11'h000},
        {1'b1, 11'h055, 1'b1, 1'b0, 11'h055},
        {1'b1, 11'h3A0, 1'b0, 1'b1, 11'h3A0},
        {1'b0, 11'h000, 1'b1, 1'b1, 11'h3A0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        pseudo = 1'b0;
    logic        locked = 1'b1;
    logic        rd = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  rdata;
    logic [10:0] frame_num;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sof_frame_counter dut_i (
        .clk            (clk),
        .rst            (rst),
        .sof_valid_i    (sof_valid),
        .sof_frame_i    (sof_frame),
        .pseudo_sof_i   (pseudo),
        .timer_locked_i (locked),
        .bus_rd_i       (rd),
        .bus_addr_i     (addr),
        .bus_rdata_o    (rdata),
        .frame_num_o    (frame_num)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 4, 8: return "R2";
            1, 5:    return "R3";
            2, 9:    return "R6";
            6:       return "R4";
            7:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic r, input logic [15:0] a, output logic [7:0] d);
        rd   = r;
        addr = a;
        #2;
        d = rdata;
        rd = 1'b0;
        #1;
    endtask

    // Checks the output and both byte registers (R7 low byte, R8 high byte)
    task automatic check_regs(input string tag, input logic [10:0] exp);
        logic [7:0] d;
        cmp(tag, frame_num, exp);
        bus_read(1'b1, LO_ADDR, d);
        cmp({tag, "/R7"}, {3'b0, d}, {3'b0, exp[7:0]});
        bus_read(1'b1, HI_ADDR, d);
        cmp({tag, "/R8"}, {3'b0, d}, {8'b0, exp[10:8]});
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_regs("R1", 11'h000);

        for (int i = 0; i < NVEC; i++) begin
            sof_valid = VEC[i][24];
            sof_frame = VEC[i][23:13];
            pseudo    = VEC[i][12];
            locked    = VEC[i][11];
            @(negedge clk);
            sof_valid = 1'b0;
            pseudo    = 1'b0;
            check_regs(vec_tag(i), VEC[i][10:0]);
        end

        // R8: all three upper bits set, reserved bits still 0
        sof_valid = 1'b1; sof_frame = 11'h7FF;
        @(negedge clk);
        sof_valid = 1'b0;
        bus_read(1'b1, HI_ADDR, d);
        cmp("R8", {3'b0, d}, 11'h007);

        // R9: other addresses and idle strobe read 0
        bus_read(1'b1, 16'hFFF9, d); cmp("R9", {3'b0, d}, 11'h000);
        bus_read(1'b1, 16'hFFFC, d); cmp("R9", {3'b0, d}, 11'h000);
        bus_read(1'b1, 16'h00FB, d); cmp("R9", {3'b0, d}, 11'h000);
        bus_read(1'b0, LO_ADDR, d);  cmp("R9", {3'b0, d}, 11'h000);
        bus_read(1'b0, HI_ADDR, d);  cmp("R9", {3'b0, d}, 11'h000);

        // R6: a run of pseudo pulses while locked
        locked = 1'b1;
        for (int k = 0; k < 5; k++) begin
            pseudo = 1'b1;
            @(negedge clk);
        end
        pseudo = 1'b0;
        check_regs("R6", 11'h7FF);

        // R3: a run of pseudo pulses while unlocked, wrapping through 0 (R4)
        locked = 1'b0;
        for (int k = 0; k < 4; k++) begin
            pseudo = 1'b1;
            @(negedge clk);
        end
        pseudo = 1'b0;
        check_regs("R3", 11'h003);

        // R1: reset in mid-run clears the number
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_regs("R1", 11'h000);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule